// File: doc/BRIEF.md
# Single-Precision Float Class Decoder

This block takes a raw 32-bit IEEE-754 single-precision operand and reports which of ten value classes it belongs to. The answer is a one-hot mask in the low ten bits of an integer-register-wide result. All higher bits of the result are zero. A classify operation in a floating-point pipeline uses it to turn a register value into an integer that software can test with a single AND.

The operand comes with a valid strobe. By default the mask is registered and appears one clock after the operand, with its own valid strobe. A parameter can remove the register, which makes the path purely combinational. The block has no exception-flag output, because classification never signals an exception. Decoding checks the exponent field (bits 30:23) for all ones or all zeros. It then checks the fraction field (bits 22:0) for zero and reads its top bit, and finally splits the result by the sign bit (bit 31).

Top module: `fp_class_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `outValid` is 0 and `outMask` is all zeros.
- R2: With the default registered variant, `outValid` equals the `inValid` value that was sampled on the previous rising clock edge.
- R3: When `outValid` is 1, exactly one of `outMask[9:0]` is set.
- R4: Bits `outMask[XLEN-1:10]` are zero at all times.
- R5: Exponent 0xFF with a zero fraction is an infinity. It sets bit 0 when the sign is 1 and bit 7 when the sign is 0.
- R6: Exponent 0xFF with a nonzero fraction is a NaN of either sign. It sets bit 9 (quiet) when fraction bit 22 is 1 and bit 8 (signaling) when fraction bit 22 is 0.
- R7: Exponent 0 with a zero fraction is a zero. It sets bit 3 when the sign is 1 and bit 4 when the sign is 0.
- R8: Exponent 0 with a nonzero fraction is subnormal. It sets bit 2 when the sign is 1 and bit 5 when the sign is 0.
- R9: Any other exponent is normal. It sets bit 1 when the sign is 1 and bit 6 when the sign is 0.
- R10: On a cycle where `inValid` is 0, `inOperand` is ignored and `outMask` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand present this cycle |
| inOperand | input | 32 | Raw single-precision bit pattern |
| outValid | output | 1 | Mask valid |
| outMask | output | XLEN | One-hot class mask, zero-extended |

## Verification
A wrong decode of the exponent or fraction shows up as a wrong bit index in `outMask` one clock after the operand. It appears only for operands on the affected boundary, so the vectors sit on every class edge: the smallest and largest subnormals and normals, the NaN payloads on both sides of the quiet bit, and both signs. A broken enable or hold path shows up on the first idle cycle as a dropped or changed mask, or as a valid strobe that lags or leads its operand by a cycle.

// File: rtl/fp_class_pkg.sv
package fp_class_pkg;
  localparam int OPER_W  = 32;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int CLASS_W = 10;
  localparam int EXP_LSB = FRAC_W;
  localparam int SIGN_IX = OPER_W - 1;

  typedef enum int {
    CLS_NEG_INF  = 0,
    CLS_NEG_NORM = 1,
    CLS_NEG_SUB  = 2,
    CLS_NEG_ZERO = 3,
    CLS_POS_ZERO = 4,
    CLS_POS_SUB  = 5,
    CLS_POS_NORM = 6,
    CLS_POS_INF  = 7,
    CLS_SNAN     = 8,
    CLS_QNAN     = 9
  } fpClass_e;

  typedef struct packed {
    logic captureEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/fp_class_ctrl.sv
module fp_class_ctrl
  import fp_class_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  assign strobes.captureEn = inValid;

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/fp_class_dp.sv
module fp_class_dp
  import fp_class_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [OPER_W-1:0] inOperand,
  output logic [XLEN-1:0]   outMask
);
  localparam int PAD_W = XLEN - CLASS_W;

  logic              signBit;
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              expAllOnes, expZero, fracZero;
  logic [CLASS_W-1:0] classVec;
  logic [XLEN-1:0]   maskNext;

  assign signBit   = inOperand[SIGN_IX];
  assign expField  = inOperand[EXP_LSB +: EXP_W];
  assign fracField = inOperand[FRAC_W-1:0];

  assign expAllOnes = &expField;
  assign expZero    = ~|expField;
  assign fracZero   = ~|fracField;

  always_comb begin
    classVec = '0;
    if (expAllOnes) begin
      if (fracZero)
        classVec[signBit ? CLS_NEG_INF : CLS_POS_INF] = 1'b1;
      else if (fracField[FRAC_W-1])
        classVec[CLS_QNAN] = 1'b1;
      else
        classVec[CLS_SNAN] = 1'b1;
    end else if (expZero) begin
      if (fracZero)
        classVec[signBit ? CLS_NEG_ZERO : CLS_POS_ZERO] = 1'b1;
      else
        classVec[signBit ? CLS_NEG_SUB : CLS_POS_SUB] = 1'b1;
    end else begin
      classVec[signBit ? CLS_NEG_NORM : CLS_POS_NORM] = 1'b1;
    end
  end

  assign maskNext = {{PAD_W{1'b0}}, classVec};

  generate
    if (REG_OUT) begin : g_reg
      logic [XLEN-1:0] maskQ;
      always_ff @(posedge clk) begin
        if (!rstN)                  maskQ <= '0;
        else if (strobes.captureEn) maskQ <= maskNext;
      end
      assign outMask = maskQ;
    end else begin : g_comb
      logic unusedClk;
      assign unusedClk = clk ^ rstN ^ strobes.captureEn;
      assign outMask = maskNext;
    end
  endgenerate
endmodule

// File: rtl/fp_class_unit.sv
module fp_class_unit
  import fp_class_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [31:0]     inOperand,
  output logic            outValid,
  output logic [XLEN-1:0] outMask
);
  ctrlStrobes_t strobes;

  fp_class_ctrl #(.REG_OUT(REG_OUT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fp_class_dp #(.XLEN(XLEN), .REG_OUT(REG_OUT)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inOperand (inOperand),
    .outMask   (outMask)
  );
endmodule

// File: rtl/fp_class_unit_chk.sv
module fp_class_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [31:0]     inOperand,
  input logic            outValid,
  input logic [XLEN-1:0] outMask
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R3
  one_hot_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(outMask[9:0]) == 1));
  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outMask[XLEN-1:10] == '0);
  // R5
  inf_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOperand[30:0] == 31'h7F80_0000) |=> (outMask[0] || outMask[7]));
  // R6
  nan_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOperand[30:23] == 8'hFF && inOperand[22:0] != 23'd0)
      |=> (outMask[9] == $past(inOperand[22])) && (outMask[8] != $past(inOperand[22])));
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outMask));
endmodule

bind fp_class_unit fp_class_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inOperand (inOperand),
  .outValid  (outValid),
  .outMask   (outMask)
);

// File: tb/fp_class_unit_tb_top.sv
module fp_class_unit_tb_top;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inValid = 1'b0;
  logic [31:0]     inOperand = '0;
  logic            outValid;
  logic [XLEN-1:0] outMask;

  int vecCount = 0;
  int failCount = 0;
  bit doneFlag = 1'b0;

  always #2 clk = ~clk;

  fp_class_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOperand(inOperand),
    .outValid(outValid), .outMask(outMask)
  );

  task automatic checkOut(input string req, input logic expValid, input logic [XLEN-1:0] expMask);
    vecCount++;
    if (outValid !== expValid || outMask !== expMask) begin
      failCount++;
      $display("FAIL %s: valid=%0b mask=%h expected valid=%0b mask=%h",
               req, outValid, outMask, expValid, expMask);
    end
  endtask

  // Apply one operand, check the mask one clock later (all checks also cover R3 and R4).
  task automatic classify(input string req, input logic [31:0] op, input int bitIx);
    @(negedge clk);
    inValid = 1'b1;
    inOperand = op;
    @(negedge clk);
    inValid = 1'b0;
    checkOut(req, 1'b1, XLEN'(1) << bitIx);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkOut("R1 in reset", 1'b0, '0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 1'b0, '0);
  endtask

  task automatic testInfinities();
    classify("R5 -inf", 32'hFF80_0000, 0);
    classify("R5 +inf", 32'h7F80_0000, 7);
  endtask

  task automatic testNans();
    classify("R6 snan min", 32'h7F80_0001, 8);
    classify("R6 qnan canon", 32'h7FC0_0000, 9);
    classify("R6 neg qnan", 32'hFFC0_0001, 9);
    classify("R6 neg snan max", 32'hFFBF_FFFF, 8);
    classify("R6 qnan all", 32'h7FFF_FFFF, 9);
  endtask

  task automatic testZeros();
    classify("R7 -0", 32'h8000_0000, 3);
    classify("R7 +0", 32'h0000_0000, 4);
  endtask

  task automatic testSubnormals();
    classify("R8 +sub min", 32'h0000_0001, 5);
    classify("R8 -sub max", 32'h807F_FFFF, 2);
    classify("R8 +sub max", 32'h007F_FFFF, 5);
  endtask

  task automatic testNormals();
    classify("R9 -norm min", 32'h8080_0000, 1);
    classify("R9 +norm min", 32'h0080_0000, 6);
    classify("R9 +norm max", 32'h7F7F_FFFF, 6);
    classify("R9 -norm max", 32'hFF7F_FFFF, 1);
    classify("R9 +one", 32'h3F80_0000, 6);
    classify("R9 -one", 32'hBF80_0000, 1);
  endtask

  // R10: idle operand changes must not disturb the held mask; R2 valid drops.
  task automatic testHold();
    classify("R10 setup", 32'h0000_0001, 5);
    @(negedge clk);
    inOperand = 32'hFF80_0000;
    @(negedge clk);
    checkOut("R10 idle hold", 1'b0, XLEN'(1) << 5);
    inOperand = 32'h7FC0_0000;
    @(negedge clk);
    checkOut("R10 idle hold 2", 1'b0, XLEN'(1) << 5);
  endtask

  // R2: back-to-back operands, each mask one clock behind its operand.
  task automatic testStream();
    @(negedge clk);
    inValid = 1'b1;
    inOperand = 32'h8000_0000;
    @(negedge clk);
    checkOut("R2 stream 0", 1'b1, XLEN'(1) << 3);
    inOperand = 32'h7F80_0001;
    @(negedge clk);
    checkOut("R2 stream 1", 1'b1, XLEN'(1) << 8);
    inOperand = 32'h4049_0FDB;
    @(negedge clk);
    checkOut("R2 stream 2", 1'b1, XLEN'(1) << 6);
    inValid = 1'b0;
    @(negedge clk);
    checkOut("R2 stream end", 1'b0, XLEN'(1) << 6);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vecCount++;
    failCount++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finishRun();
  end

  initial begin
    testReset();
    testInfinities();
    testNans();
    testZeros();
    testSubnormals();
    testNormals();
    testHold();
    testStream();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule